// File: doc/BRIEF.md
# Doorbell Message Handshake Engine

This block is the device-side doorbell of a message-based storage controller. A host on a 32-bit register bus writes a function word into the doorbell. For a handshake, that word is followed by a stated number of 32-bit request words. The block gathers the request words into a local buffer and signals a responder that a request is ready. The responder can read the buffered words back by index, and it supplies the reply length and the reply halfwords.

The reply goes back to the host 16 bits at a time through the low half of the doorbell. Each halfword is announced by a flag in the interrupt status register. The host acknowledges each halfword by writing 1 to that register, and the next halfword is then presented.

When no reply data is pending, a doorbell read carries a controller state code, an in-use flag and the initiator identity. Function writes that are malformed, or that arrive while a handshake is in progress, raise a sticky error flag. Two reset functions clear that flag.

Top module: `doorbell_hs`

## Requirements
- R1: After reset, a doorbell read (address 0x00) returns 0x1100_0000: state code 1 (ready) in bits 31:28, in-use bit 27 clear, initiator identity 1 in bits 26:24, and zero in bits 15:0. An interrupt status read (address 0x30) returns 0.
- R2: A doorbell write whose bits 31:24 are 0x42 starts a handshake. Bits 23:16 of that word give N. The next N doorbell writes are stored as request words 0 to N-1. After the last of them, reqDone is high for exactly one cycle, reqCount equals N, and reqRdData returns stored word k when reqRdIdx is k.
- R3: From the function write until the last reply halfword is acknowledged, doorbell reads show in-use bit 27 set and state code 2 in bits 31:28. After the last acknowledge they show state code 1 with bit 27 clear.
- R4: While a reply halfword is pending, interrupt status bit 0 is 1 and doorbell bits 15:0 carry the halfword selected by replyIdx. Halfwords are presented in index order 0 to L-1, where L is replyLen sampled in the cycle reqDone is high. When no halfword is pending, doorbell bits 15:0 read 0.
- R5: A write to interrupt status with bit 0 set, while a halfword is pending, clears bit 0. The next halfword then becomes pending. A write with bit 0 clear has no effect.
- R6: If the reply length is zero, the block returns to idle right after reqDone, and interrupt status bit 0 never becomes 1.
- R7: A handshake function word with N = 0 collects no words and raises reqDone in the cycle after the function write, with reqCount 0.
- R8: A doorbell write after the request has been collected and before the last acknowledge is ignored: the pending halfword and the reply position are unchanged. Such a write sets the error flag in interrupt status bit 1, which stays set while idle.
- R9: In idle, function codes 0x40 and 0x41 clear the error flag. Code 0x43 changes nothing. Any code other than 0x40 to 0x43 sets the error flag.
- R10: A handshake function word with N greater than MAX_REQ_WORDS (32 by default) sets the error flag and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register bus address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational, zero when no read) |
| reqDone | output | 1 | One-cycle pulse: request collected |
| reqCount | output | 8 | Number of request words in the collected request |
| reqRdIdx | input | 5 | Responder read index into the request buffer |
| reqRdData | output | 32 | Request word at reqRdIdx |
| replyLen | input | 8 | Reply length in halfwords, sampled while reqDone is high |
| replyIdx | output | 8 | Index of the reply halfword being presented |
| replyHalf | input | 16 | Reply halfword at replyIdx from the responder |

## Verification
The hardest states to reach from the ports lie inside the reply phase. These are a misplaced function write, or an acknowledge with bit 0 clear, arriving while a halfword is pending. The stimulus reaches them by stopping a handshake part way: it collects the request and polls until the first halfword is pending. It then issues the stray writes, checks that the halfword and the in-use state are unchanged, and completes the reply. Zero-length replies, empty requests and a full buffer of 32 words come from the vector table.

// File: rtl/dbh_pkg.sv
package dbh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_LAUNCH,
    ST_REPLY
  } hsState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic storeWord;
    logic setPend;
    logic clrPend;
    logic setErr;
    logic clrErr;
    logic busy;
  } hsStrobe_t;

  localparam logic [7:0] FN_MSG_RESET    = 8'h40;
  localparam logic [7:0] FN_IO_RESET     = 8'h41;
  localparam logic [7:0] FN_HANDSHAKE    = 8'h42;
  localparam logic [7:0] FN_REPLY_REMOVE = 8'h43;

  localparam logic [3:0] STATE_READY = 4'h1;
  localparam logic [3:0] STATE_OPER  = 4'h2;

endpackage

// File: rtl/dbh_ctrl.sv
module dbh_ctrl
  import dbh_pkg::*;
#(
  parameter int MAX_REQ_WORDS = 32,
  parameter int IDX_W = $clog2(MAX_REQ_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dbWr,
  input  logic             ackWr,
  input  logic [7:0]       fnCode,
  input  logic [7:0]       fnCount,
  input  logic             pend,
  input  logic [7:0]       replyLen,
  output hsStrobe_t        strb,
  output logic [IDX_W-1:0] storeIdx,
  output logic             reqDone,
  output logic [7:0]       reqCount,
  output logic [7:0]       replyIdx
);

  localparam logic [7:0] MAX_CNT = 8'(MAX_REQ_WORDS);

  hsState_t   state;
  logic [7:0] reqCnt;
  logic [7:0] wordIdx;
  logic [7:0] halfIdx;
  logic [7:0] lenReg;
  logic       tooLong;
  logic       knownFn;
  logic       lastHalf;

  assign tooLong  = fnCount > MAX_CNT;
  assign knownFn  = (fnCode == FN_MSG_RESET) || (fnCode == FN_IO_RESET) ||
                    (fnCode == FN_REPLY_REMOVE);
  assign lastHalf = halfIdx == (lenReg - 8'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqCnt  <= '0;
      wordIdx <= '0;
      halfIdx <= '0;
      lenReg  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (dbWr && fnCode == FN_HANDSHAKE && !tooLong) begin
            reqCnt  <= fnCount;
            wordIdx <= '0;
            state   <= (fnCount == 8'd0) ? ST_LAUNCH : ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (dbWr) begin
            wordIdx <= wordIdx + 8'd1;
            if (wordIdx == reqCnt - 8'd1) state <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          lenReg  <= replyLen;
          halfIdx <= '0;
          state   <= (replyLen == 8'd0) ? ST_IDLE : ST_REPLY;
        end
        ST_REPLY: begin
          if (ackWr && pend) begin
            if (lastHalf) state <= ST_IDLE;
            else          halfIdx <= halfIdx + 8'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.storeWord = (state == ST_COLLECT) && dbWr;
    strb.setPend   = (state == ST_REPLY) && !pend;
    strb.clrPend   = (state == ST_REPLY) && ackWr && pend;
    strb.setErr    = dbWr && (((state == ST_IDLE) &&
                               ((fnCode == FN_HANDSHAKE) ? tooLong : !knownFn)) ||
                              (state == ST_LAUNCH) || (state == ST_REPLY));
    strb.clrErr    = (state == ST_IDLE) && dbWr &&
                     ((fnCode == FN_MSG_RESET) || (fnCode == FN_IO_RESET));
    strb.busy      = state != ST_IDLE;
  end

  assign storeIdx = wordIdx[IDX_W-1:0];
  assign reqDone  = state == ST_LAUNCH;
  assign reqCount = reqCnt;
  assign replyIdx = halfIdx;

  // R2: the collected-request pulse lasts a single cycle
  p_launch_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  // R6: an empty reply returns straight to idle with nothing pending
  p_zero_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LAUNCH && replyLen == 8'd0) |=> (state == ST_IDLE && !pend));

  // R4: the reply position never runs past the sampled length
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REPLY) |-> (halfIdx < lenReg));

  // R8: a doorbell write during the reply does not move the reply position
  p_ignore_mid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REPLY && dbWr && !ackWr) |=> (halfIdx == $past(halfIdx)));

endmodule

// File: rtl/dbh_data.sv
module dbh_data
  import dbh_pkg::*;
#(
  parameter int MAX_REQ_WORDS = 32,
  parameter int IDX_W = $clog2(MAX_REQ_WORDS),
  parameter logic [7:0] DB_ADDR = 8'h00,
  parameter logic [7:0] IS_ADDR = 8'h30,
  parameter logic [2:0] INIT_ID = 3'h1
) (
  input  logic             clk,
  input  logic             rstN,
  input  hsStrobe_t        strb,
  input  logic [IDX_W-1:0] storeIdx,
  input  logic [31:0]      wrData,
  input  logic [IDX_W-1:0] reqRdIdx,
  output logic [31:0]      reqRdData,
  input  logic [15:0]      replyHalf,
  input  logic             rdEn,
  input  logic [7:0]       rdAddr,
  output logic [31:0]      rdData,
  output logic             pend
);

  logic [31:0] reqBuf [MAX_REQ_WORDS];
  logic        err;

  always_ff @(posedge clk) begin
    if (strb.storeWord) reqBuf[storeIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (strb.clrPend)     pend <= 1'b0;
      else if (strb.setPend) pend <= 1'b1;
      if (strb.setErr)      err <= 1'b1;
      else if (strb.clrErr) err <= 1'b0;
    end
  end

  assign reqRdData = reqBuf[reqRdIdx];

  always_comb begin
    rdData = '0;
    if (rdEn && rdAddr == DB_ADDR)
      rdData = {strb.busy ? STATE_OPER : STATE_READY, strb.busy, INIT_ID,
                8'h00, pend ? replyHalf : 16'h0000};
    else if (rdEn && rdAddr == IS_ADDR)
      rdData = {30'h0, err, pend};
  end

  // R4: a halfword can only be pending inside an active handshake
  p_pend_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    pend |-> strb.busy);

  // R2: a collected request word lands in the slot it was aimed at
  p_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeWord |=> (reqBuf[$past(storeIdx)] == $past(wrData)));

  // R5: an acknowledge drops the pending flag for at least one cycle
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrPend |=> !pend);

endmodule

// File: rtl/doorbell_hs.sv
module doorbell_hs
  import dbh_pkg::*;
#(
  parameter int MAX_REQ_WORDS = 32,
  parameter logic [7:0] DB_ADDR = 8'h00,
  parameter logic [7:0] IS_ADDR = 8'h30,
  parameter logic [2:0] INIT_ID = 3'h1,
  localparam int IDX_W = $clog2(MAX_REQ_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             reqDone,
  output logic [7:0]       reqCount,
  input  logic [IDX_W-1:0] reqRdIdx,
  output logic [31:0]      reqRdData,
  input  logic [7:0]       replyLen,
  output logic [7:0]       replyIdx,
  input  logic [15:0]      replyHalf
);

  hsStrobe_t        strb;
  logic [IDX_W-1:0] storeIdx;
  logic             pend;
  logic             dbWr;
  logic             ackWr;

  assign dbWr  = regWrEn && (regAddr == DB_ADDR);
  assign ackWr = regWrEn && (regAddr == IS_ADDR) && regWrData[0];

  dbh_ctrl #(.MAX_REQ_WORDS(MAX_REQ_WORDS), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .dbWr(dbWr), .ackWr(ackWr),
    .fnCode(regWrData[31:24]), .fnCount(regWrData[23:16]),
    .pend(pend), .replyLen(replyLen), .strb(strb), .storeIdx(storeIdx),
    .reqDone(reqDone), .reqCount(reqCount), .replyIdx(replyIdx)
  );

  dbh_data #(.MAX_REQ_WORDS(MAX_REQ_WORDS), .IDX_W(IDX_W), .DB_ADDR(DB_ADDR),
             .IS_ADDR(IS_ADDR), .INIT_ID(INIT_ID)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .storeIdx(storeIdx),
    .wrData(regWrData), .reqRdIdx(reqRdIdx), .reqRdData(reqRdData),
    .replyHalf(replyHalf), .rdEn(regRdEn), .rdAddr(regAddr),
    .rdData(regRdData), .pend(pend)
  );

endmodule

// File: tb/test_doorbell_hs.sv
module test_doorbell_hs;

  localparam int IDX_W = 5;
  localparam int NVEC = 6;
  // {request words, reply halfwords, seed}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1,  8'd2, 8'h11},
    {8'd3,  8'd1, 8'h22},
    {8'd4,  8'd6, 8'h33},
    {8'd0,  8'd3, 8'h44},
    {8'd2,  8'd0, 8'h55},
    {8'd32, 8'd4, 8'h66}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [7:0]       regAddr = '0;
  logic             regWrEn = 1'b0;
  logic             regRdEn = 1'b0;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic             reqDone;
  logic [7:0]       reqCount;
  logic [IDX_W-1:0] reqRdIdx = '0;
  logic [31:0]      reqRdData;
  logic [7:0]       replyLen = '0;
  logic [7:0]       replyIdx;
  logic [15:0]      replyHalf;
  logic [7:0]       curSeed = '0;

  int nChecks = 0;
  int nErrs = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign replyHalf = {curSeed, replyIdx} ^ 16'h5A00;

  doorbell_hs i_doorbell_hs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .reqDone(reqDone), .reqCount(reqCount), .reqRdIdx(reqRdIdx),
    .reqRdData(reqRdData), .replyLen(replyLen), .replyIdx(replyIdx),
    .replyHalf(replyHalf)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 100000 && !finished) begin
      nErrs = nErrs + 1;
      nChecks = nChecks + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nErrs = nErrs + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic waitPend(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int k = 0; k < 16 && !ok; k++) begin
      @(negedge clk);
      regRead(8'h30, v);
      ok = v[0];
    end
  endtask

  function automatic logic [31:0] reqWord(input logic [7:0] seed, input int i);
    return {seed, 8'(i), seed ^ 8'hA5, 8'(i * 3)};
  endfunction

  task automatic runHs(input logic [7:0] n, input logic [7:0] len, input logic [7:0] seed);
    logic [31:0] v;
    bit ok;
    replyLen = len;
    curSeed = seed;
    regWrite(8'h00, {8'h42, n, 16'h0});
    if (n != 0) begin
      regRead(8'h00, v);
      check("R3 busy after function word", {28'h0, v[31:28]}, 32'h2);
      check("R3 in-use after function word", {31'h0, v[27]}, 32'h1);
      for (int i = 0; i < int'(n); i++) regWrite(8'h00, reqWord(seed, i));
      check("R2 reqDone after last word", {31'h0, reqDone}, 32'h1);
      check("R2 reqCount", {24'h0, reqCount}, {24'h0, n});
    end else begin
      check("R7 reqDone on empty request", {31'h0, reqDone}, 32'h1);
      check("R7 reqCount zero", {24'h0, reqCount}, 32'h0);
    end
    @(negedge clk);
    check("R2 reqDone one cycle", {31'h0, reqDone}, 32'h0);
    for (int i = 0; i < int'(n); i++) begin
      reqRdIdx = IDX_W'(i);
      #1 check("R2 buffered word", reqRdData, reqWord(seed, i));
    end
    if (len == 0) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        regRead(8'h30, v);
        check("R6 no pending halfword", {31'h0, v[0]}, 32'h0);
      end
      regRead(8'h00, v);
      check("R6 idle after empty reply", v, 32'h1100_0000);
    end else begin
      for (int j = 0; j < int'(len); j++) begin
        waitPend(ok);
        check("R4 halfword pending", {31'h0, ok}, 32'h1);
        regRead(8'h00, v);
        check("R4 halfword value", {16'h0, v[15:0]}, {16'h0, {seed, 8'(j)} ^ 16'h5A00});
        check("R3 in-use during reply", {31'h0, v[27]}, 32'h1);
        regWrite(8'h30, 32'h1);
        regRead(8'h30, v);
        check("R5 ack clears bit0", {31'h0, v[0]}, 32'h0);
      end
      regRead(8'h00, v);
      check("R3 idle after last ack", v, 32'h1100_0000);
      repeat (3) @(negedge clk);
      regRead(8'h30, v);
      check("R5 nothing pending after last ack", {31'h0, v[0]}, 32'h0);
    end
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRead(8'h00, v);
    check("R1 doorbell reset value", v, 32'h1100_0000);
    regRead(8'h30, v);
    check("R1 status reset value", v, 32'h0);
    check("R1 reqDone low", {31'h0, reqDone}, 32'h0);

    for (int t = 0; t < NVEC; t++)
      runHs(VEC[t][23:16], VEC[t][15:8], VEC[t][7:0]);

    // Stray writes in the middle of a reply
    replyLen = 8'd2;
    curSeed = 8'h77;
    regWrite(8'h00, 32'h4201_0000);
    regWrite(8'h00, 32'hDEAD_BEEF);
    waitPend(ok);
    check("R4 first halfword pending", {31'h0, ok}, 32'h1);
    regWrite(8'h30, 32'h0);
    regRead(8'h30, v);
    check("R5 zero write keeps bit0", {31'h0, v[0]}, 32'h1);
    regRead(8'h00, v);
    check("R5 zero write keeps halfword", {16'h0, v[15:0]}, 32'h2D00);
    regWrite(8'h00, 32'h4203_0000);
    regRead(8'h30, v);
    check("R8 mid-handshake error set", v, 32'h3);
    regRead(8'h00, v);
    check("R8 halfword unchanged", v, 32'h2900_2D00);
    regWrite(8'h30, 32'h1);
    waitPend(ok);
    regRead(8'h00, v);
    check("R8 second halfword after stray write", {16'h0, v[15:0]}, 32'h2D01);
    regWrite(8'h30, 32'h1);
    regRead(8'h00, v);
    check("R8 back to idle", v, 32'h1100_0000);
    regRead(8'h30, v);
    check("R8 error sticky in idle", v, 32'h2);

    // Function codes in idle
    regWrite(8'h00, 32'h4300_0000);
    regRead(8'h30, v);
    check("R9 0x43 leaves error", v, 32'h2);
    regRead(8'h00, v);
    check("R9 0x43 stays idle", v, 32'h1100_0000);
    regWrite(8'h00, 32'h4000_0000);
    regRead(8'h30, v);
    check("R9 0x40 clears error", v, 32'h0);
    regWrite(8'h00, 32'h5500_0000);
    regRead(8'h30, v);
    check("R9 unknown code sets error", v, 32'h2);
    regWrite(8'h00, 32'h4100_0000);
    regRead(8'h30, v);
    check("R9 0x41 clears error", v, 32'h0);

    // Oversized request
    regWrite(8'h00, 32'h4221_0000);
    regRead(8'h30, v);
    check("R10 oversized sets error", v, 32'h2);
    regRead(8'h00, v);
    check("R10 oversized stays idle", v, 32'h1100_0000);
    check("R10 no reqDone", {31'h0, reqDone}, 32'h0);
    regWrite(8'h00, 32'h4000_0000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule